// File: doc/BRIEF.md
# Bus Wait-State and Strobe Controller

This block is the glue between an 8-bit CPU and slow memory. It drives the CPU ready line and makes the active-low read and write strobes for memory. Its inputs are the CPU direction line, the bus clock phase and a wait-state request that carries a cycle count. Two mode inputs change how it behaves. The bypass input turns wait states off so that a slow external clock can step the bus. The halt input pulls ready low to freeze the CPU.

A strobe is asserted only in the high phase of the bus clock. While ready is held low it stays asserted, so a slow device sees one unbroken access. When bypass is on, a low ready no longer stretches the strobes. If halt and bypass are both on, ready is still low, but the strobes keep following the clock phase. An external programmer can then clock reads and writes past the halted CPU.

Top module: `ws_bus_ctl`

## Requirements
- R1: After reset, `ready`, `rd_n` and `wr_n` are always driven to 0 or 1. They are never unknown or floating.
- R2: With `bypass`=1 and `halt`=0, `ready` is 1. A `wait_req` seen while `bypass`=1 starts no wait. Once `bypass` returns to 0, `ready` stays 1.
- R3: With `halt`=1, `ready` is 0 whatever the value of `bypass`. Halt has priority.
- R4: With `ready`=1, `rd_n` is 0 exactly when `rw`=1 (read) and `phi`=1. `wr_n` is 0 exactly when `rw`=0 (write) and `phi`=1. Otherwise both are 1.
- R5: `rd_n` and `wr_n` are never 0 at the same time.
- R6: With `ready`=0 and `bypass`=0, the strobe chosen by `rw` is 0 whatever the value of `phi`.
- R7: With `bypass`=1, the strobes follow R4 from `phi` and `rw` even while `ready` is 0.
- R8: A `wait_req` sampled at a clock edge with `wait_len`=N (1 to 7), with no wait running and `bypass`=0, makes `ready` 0 for exactly N cycles starting after that edge. After that `ready` returns to 1. N=0 adds no wait.
- R9: A `wait_req` that arrives while a wait is running is ignored. It neither reloads nor extends the count.
- R10: Asserting `rst_n` low clears any running wait at once. `ready` is then 1, or 0 if `halt`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one tick per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| phi | input | 1 | Bus clock phase, 1 = data phase |
| rw | input | 1 | CPU direction, 1 = read, 0 = write |
| wait_req | input | 1 | Request to insert wait states for this access |
| wait_len | input | 3 | Number of wait cycles to insert |
| bypass | input | 1 | Disables wait states and strobe stretching |
| halt | input | 1 | Forces ready low |
| ready | output | 1 | CPU ready line, always driven |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
A corrupted wait counter shows up at `ready` in the very next cycle. A count that is left too long or too short moves the cycle where `ready` rises. So the bench counts the low cycles for every length from 0 to 7, and for a second request sent during a running wait. An error in the strobe path shows up at once, in the same cycle. The bench covers all sixteen combinations of halt, bypass, direction and phase, comparing both strobes and ready. Reset applied during a wait must bring `ready` back before the next edge.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int unsigned WAIT_W = 3;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } bus_dir_e;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
  } strobe_t;
endpackage

// File: rtl/ws_wait_counter.sv
module ws_wait_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic             wait_req,
  input  logic [CNT_W-1:0] wait_len,
  output logic             busy
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // next state: bypass clears, running count steps down, idle count may load
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (bypass) begin
      cnt_d  = CNT_ZERO;
      cnt_en = (cnt_q != CNT_ZERO);
    end else if (cnt_q != CNT_ZERO) begin
      cnt_d  = cnt_q - CNT_ONE;
      cnt_en = 1'b1;
    end else if (wait_req) begin
      cnt_d  = wait_len;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != CNT_ZERO);

  // R9: a running count only steps down by one, never reloads
  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bypass) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R2: bypass leaves no wait pending
  p_bypass_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !busy);
endmodule

// File: rtl/ws_ready_ctl.sv
module ws_ready_ctl (
  input  logic halt,
  input  logic bypass,
  input  logic busy,
  output logic ready
);
  // halt wins over bypass; bypass hides the counter
  always_comb begin
    if (halt) begin
      ready = 1'b0;
    end else if (bypass) begin
      ready = 1'b1;
    end else begin
      ready = !busy;
    end
  end
endmodule

// File: rtl/ws_strobe_gen.sv
module ws_strobe_gen
  import ws_pkg::*;
(
  input  logic    phi,
  input  logic    rw,
  input  logic    ready,
  input  logic    bypass,
  output strobe_t strobe
);
  logic hold_open;   // ready seen by the strobe path, forced high under bypass
  logic active;
  bus_dir_e dir;

  always_comb begin
    dir       = bus_dir_e'(rw);
    hold_open = ready | bypass;
    active    = phi | !hold_open;
    strobe.rd_n = !(active && (dir == DIR_READ));
    strobe.wr_n = !(active && (dir == DIR_WRITE));
  end
endmodule

// File: rtl/ws_bus_ctl.sv
module ws_bus_ctl
  import ws_pkg::*;
#(
  parameter int unsigned CNT_W = WAIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi,
  input  logic             rw,
  input  logic             wait_req,
  input  logic [CNT_W-1:0] wait_len,
  input  logic             bypass,
  input  logic             halt,
  output logic             ready,
  output logic             rd_n,
  output logic             wr_n
);
  logic    busy;
  strobe_t strobe;

  ws_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass   (bypass),
    .wait_req (wait_req),
    .wait_len (wait_len),
    .busy     (busy)
  );

  ws_ready_ctl u_rdy (
    .halt   (halt),
    .bypass (bypass),
    .busy   (busy),
    .ready  (ready)
  );

  ws_strobe_gen u_stb (
    .phi    (phi),
    .rw     (rw),
    .ready  (ready),
    .bypass (bypass),
    .strobe (strobe)
  );

  assign rd_n = strobe.rd_n;
  assign wr_n = strobe.wr_n;

  p_driven_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({ready, rd_n, wr_n}));

  p_bypass_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !halt) |-> ready);

  p_halt_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !ready);

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_n, wr_n}) >= 1);

  p_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !bypass) |-> (rw ? !rd_n : !wr_n));

  p_follow_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !phi) |-> (rd_n && wr_n));

  p_wait_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wait_req && !bypass && !halt && (wait_len != '0)) |=> !ready);
endmodule

// File: tb/ws_bus_ctl_test.sv
module ws_bus_ctl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic phi, rw, wait_req, bypass, halt;
  logic [2:0] wait_len;
  logic ready, rd_n, wr_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ws_bus_ctl uut (
    .clk(clk), .rst_n(rst_n), .phi(phi), .rw(rw), .wait_req(wait_req),
    .wait_len(wait_len), .bypass(bypass), .halt(halt),
    .ready(ready), .rd_n(rd_n), .wr_n(wr_n)
  );

  // {halt, bypass, rw, phi, exp_ready, exp_rd_n, exp_wr_n}, counter idle
  localparam logic [6:0] VEC [16] = '{
    7'b0000_111, 7'b0001_110, 7'b0010_111, 7'b0011_101,
    7'b0100_111, 7'b0101_110, 7'b0110_111, 7'b0111_101,
    7'b1000_010, 7'b1001_010, 7'b1010_001, 7'b1011_001,
    7'b1100_011, 7'b1101_010, 7'b1110_011, 7'b1111_001
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue a request at one edge, then count consecutive low-ready negedges
  task automatic run_wait(input logic [2:0] len, output int lows);
    @(negedge clk);
    wait_req = 1'b1; wait_len = len;
    @(negedge clk);
    wait_req = 1'b0;
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      if (ready == 1'b0) lows++;
      else break;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int lows;
    rst_n = 1'b0; phi = 1'b0; rw = 1'b1; wait_req = 1'b0;
    wait_len = 3'd0; bypass = 1'b0; halt = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 reset ready", ready, 1);
    chk("R1 reset strobes", {rd_n, wr_n}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R2
    for (int v = 0; v < 16; v++) begin
      {halt, bypass, rw, phi} = VEC[v][6:3];
      #1;
      chk(v >= 12 ? "R7 R3 vec" : v >= 8 ? "R6 R3 vec" : v >= 4 ? "R2 R4 vec" : "R4 vec",
          {ready, rd_n, wr_n}, VEC[v][2:0]);
      chk("R5 vec", (rd_n | wr_n), 1);
      @(negedge clk);
    end
    halt = 1'b0; bypass = 1'b0; phi = 1'b0; rw = 1'b1;

    // R8 every length
    for (int n = 0; n < 8; n++) begin
      run_wait(3'(n), lows);
      chk($sformatf("R8 len %0d lows", n), lows, n);
      chk("R8 ready back", ready, 1);
    end

    // R6 during a counted wait: read strobe held across phi low
    @(negedge clk);
    wait_req = 1'b1; wait_len = 3'd3; rw = 1'b1; phi = 1'b0;
    @(negedge clk);
    wait_req = 1'b0;
    #1;
    chk("R6 counted stretch ready", ready, 0);
    chk("R6 counted stretch rd_n", rd_n, 0);
    repeat (4) @(negedge clk);

    // R9 second request during a running wait
    @(negedge clk);
    wait_req = 1'b1; wait_len = 3'd5;
    @(negedge clk);
    wait_req = 1'b0; lows = 1;
    @(negedge clk);
    wait_req = 1'b1; wait_len = 3'd7;
    lows++;
    @(negedge clk);
    wait_req = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (ready == 1'b0) lows++;
      else break;
      @(negedge clk);
    end
    chk("R9 no extension lows", lows, 5);

    // R2 request under bypass loads nothing
    @(negedge clk);
    bypass = 1'b1; wait_req = 1'b1; wait_len = 3'd6;
    @(negedge clk);
    chk("R2 bypass ready", ready, 1);
    bypass = 1'b0; wait_req = 1'b0;
    #1;
    chk("R2 after bypass ready", ready, 1);

    // R10 reset mid-wait, with and without halt
    run_wait(3'd0, lows);
    @(negedge clk);
    wait_req = 1'b1; wait_len = 3'd7;
    @(negedge clk);
    wait_req = 1'b0;
    chk("R10 wait running", ready, 0);
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears wait", ready, 1);
    halt = 1'b1;
    #1;
    chk("R10 reset with halt", ready, 0);
    halt = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 no leftover wait", ready, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule